// File: doc/BRIEF.md
# Single-Operand Byte Modifier

This block computes the unary operations of an 8-bit CPU's read-modify-write instruction group. It takes one operand byte, which the surrounding core has already fetched from the accumulator, the index register or memory. The low nibble of the opcode selects the operation. The block returns the new byte, the updated negative, zero and carry flags, and an enable that tells the core whether to write the byte back.

Operands are accepted on a cycle with `in_valid` high. Results appear registered one clock later with `out_valid` high. When no operation is accepted, the outputs keep their last values.

Opcode nibbles with no defined operation raise `illegal`. In that case the operand and the incoming flags pass through unchanged, and write-back is suppressed. Operand sourcing and bus sequencing are left to the core.

Top module: `rmw_unit`

## Requirements
- R1: After a synchronous active-low reset, `out_valid`, `result`, `n_out`, `z_out`, `c_out`, `wr_en` and `illegal` are all 0.
- R2: `out_valid` is high exactly one cycle after a cycle with `in_valid` high. After a cycle with `in_valid` low, `out_valid` is 0 and all other outputs keep their previous values.
- R3: Nibble 0x0 produces the two's complement of the operand. It sets C when the result is nonzero, and N from the result's bit 7 and Z when the result is zero (the N/Z rule of every legal operation unless stated otherwise).
- R4: Nibble 0x3 produces the bitwise inverse of the operand and always sets C to 1.
- R5: Nibble 0x4 shifts right logically, with 0 entering bit 7. C takes the old bit 0 and N is forced to 0.
- R6: Nibble 0x6 rotates right through the carry: C_in enters bit 7 and C takes the old bit 0. Nibble 0x9 rotates left through the carry: C_in enters bit 0 and C takes the old bit 7.
- R7: Nibble 0x7 shifts right arithmetically, keeping bit 7, and C takes the old bit 0. Nibble 0x8 shifts left with 0 entering bit 0, and C takes the old bit 7.
- R8: Nibble 0xA decrements and nibble 0xC increments, modulo 256. C keeps `c_in`.
- R9: Nibble 0xD returns the operand unchanged with N/Z updated, C equal to `c_in`, and `wr_en` 0.
- R10: Nibble 0xF returns 0 with N=0 and Z=1. C keeps `c_in`.
- R11: Nibbles 0x1, 0x2, 0x5, 0xB and 0xE set `illegal` to 1 and `wr_en` to 0. The result equals the operand, and the flags equal `n_in`, `z_in` and `c_in`.
- R12: Every legal nibble except 0xD sets `wr_en` to 1 and `illegal` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Accept an operation this cycle |
| op_nib | input | 4 | Low opcode nibble selecting the operation |
| operand | input | DATA_W | Operand byte |
| c_in | input | 1 | Current carry flag |
| n_in | input | 1 | Current negative flag |
| z_in | input | 1 | Current zero flag |
| out_valid | output | 1 | Result registered from the previous cycle |
| result | output | DATA_W | Modified byte |
| n_out | output | 1 | New negative flag |
| z_out | output | 1 | New zero flag |
| c_out | output | 1 | New carry flag |
| wr_en | output | 1 | Write the result back |
| illegal | output | 1 | Nibble has no defined operation |

## Verification
The bench builds the block with the default `DATA_W` of 8. At that width, every operand value can be swept against every nibble and both carry-in values. This covers the wrap points of increment and decrement, the zero and 0x80 corners of negation, and the bit-7/bit-0 carries of all shifts exhaustively. Idle cycles with changing inputs are mixed in to show that the outputs hold.

// File: rtl/rmw_pkg.sv
// Shared definitions for the single-operand byte modifier.
// Assumes the opcode nibble is 4 bits; operation codes equal their nibble.
package rmw_pkg;
    localparam int NIB_W = 4;

    typedef enum logic [NIB_W-1:0] {
        OP_NEG = 4'h0,
        OP_ILL = 4'h1,
        OP_COM = 4'h3,
        OP_LSR = 4'h4,
        OP_ROR = 4'h6,
        OP_ASR = 4'h7,
        OP_LSL = 4'h8,
        OP_ROL = 4'h9,
        OP_DEC = 4'hA,
        OP_INC = 4'hC,
        OP_TST = 4'hD,
        OP_CLR = 4'hF
    } rmw_op_e;
endpackage

// File: rtl/rmw_decode.sv
// Maps the low opcode nibble to an operation code and flags unused nibbles.
// Assumes: pure combinational; unused nibbles all map to OP_ILL.
module rmw_decode
    import rmw_pkg::*;
(
    input  logic [NIB_W-1:0] nib,
    output rmw_op_e          op,
    output logic             ill
);
    // Decode the nibble into an operation.
    always_comb begin
        ill = 1'b0;
        case (nib)
            4'h0:    op = OP_NEG;
            4'h3:    op = OP_COM;
            4'h4:    op = OP_LSR;
            4'h6:    op = OP_ROR;
            4'h7:    op = OP_ASR;
            4'h8:    op = OP_LSL;
            4'h9:    op = OP_ROL;
            4'hA:    op = OP_DEC;
            4'hC:    op = OP_INC;
            4'hD:    op = OP_TST;
            4'hF:    op = OP_CLR;
            default: begin
                op  = OP_ILL;
                ill = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/rmw_datapath.sv
// Computes the modified value, the N/Z/C flags and the write-back enable.
// Assumes: combinational; the caller registers the outputs. Illegal
// operations pass the operand and flags through without write-back.
module rmw_datapath
    import rmw_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  rmw_op_e            op,
    input  logic [DATA_W-1:0]  a,
    input  logic               cin,
    input  logic               nin,
    input  logic               zin,
    output logic [DATA_W-1:0]  res,
    output logic               n,
    output logic               z,
    output logic               c,
    output logic               wr
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] val;

    // Form the new value and the carry for each operation.
    always_comb begin
        val = a;
        c   = cin;
        case (op)
            OP_NEG: begin val = '0 - a;             c = |val;  end
            OP_COM: begin val = ~a;                 c = 1'b1;  end
            OP_LSR: begin val = {1'b0, a[MSB:1]};   c = a[0];  end
            OP_ROR: begin val = {cin, a[MSB:1]};    c = a[0];  end
            OP_ASR: begin val = {a[MSB], a[MSB:1]}; c = a[0];  end
            OP_LSL: begin val = {a[MSB-1:0], 1'b0}; c = a[MSB]; end
            OP_ROL: begin val = {a[MSB-1:0], cin};  c = a[MSB]; end
            OP_DEC: val = a - 1'b1;
            OP_INC: val = a + 1'b1;
            OP_TST: val = a;
            OP_CLR: val = '0;
            default: val = a;
        endcase
    end

    // Derive N, Z and write-back from the new value and operation.
    always_comb begin
        res = val;
        n   = val[MSB];
        z   = (val == '0);
        wr  = 1'b1;
        case (op)
            OP_LSR, OP_CLR: n = 1'b0;
            OP_TST:         wr = 1'b0;
            OP_ILL: begin
                n  = nin;
                z  = zin;
                wr = 1'b0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rmw_unit.sv
// Top of the single-operand byte modifier: decode, compute, register.
// Assumes: one operation per accepted cycle, results one clock later;
// outputs hold when nothing is accepted; synchronous active-low reset.
module rmw_unit
    import rmw_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        op_nib,
    input  logic [DATA_W-1:0] operand,
    input  logic              c_in,
    input  logic              n_in,
    input  logic              z_in,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              n_out,
    output logic              z_out,
    output logic              c_out,
    output logic              wr_en,
    output logic              illegal
);
    rmw_op_e           op;
    logic              dec_ill;
    logic [DATA_W-1:0] dp_res;
    logic              dp_n, dp_z, dp_c, dp_wr;

    rmw_decode u_dec (
        .nib (op_nib),
        .op  (op),
        .ill (dec_ill)
    );

    rmw_datapath #(.DATA_W(DATA_W)) u_dp (
        .op  (op),
        .a   (operand),
        .cin (c_in),
        .nin (n_in),
        .zin (z_in),
        .res (dp_res),
        .n   (dp_n),
        .z   (dp_z),
        .c   (dp_c),
        .wr  (dp_wr)
    );

    // Register the outcome of an accepted operation; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            n_out     <= 1'b0;
            z_out     <= 1'b0;
            c_out     <= 1'b0;
            wr_en     <= 1'b0;
            illegal   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result  <= dp_res;
                n_out   <= dp_n;
                z_out   <= dp_z;
                c_out   <= dp_c;
                wr_en   <= dp_wr;
                illegal <= dec_ill;
            end
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(result) && $stable(c_out)); // R2
    AST_ZERO_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !illegal |-> z_out == (result == '0)); // R3
    AST_INVERT_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && op_nib == 4'h3 |=> c_out); // R4
    AST_LSR_NOT_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && op_nib == 4'h4 |=> !n_out); // R5
    AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && op_nib == 4'hD |=> !wr_en && result == $past(operand)); // R9
    AST_CLEAR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && op_nib == 4'hF |=> !n_out && z_out && result == '0); // R10
    AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !wr_en); // R11
    AST_LEGAL_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !illegal && $past(op_nib) != 4'hD |-> wr_en); // R12
endmodule

// File: tb/tb_rmw_unit.sv
module tb_rmw_unit;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [3:0]   op_nib = '0;
    logic [W-1:0] operand = '0;
    logic         c_in = 1'b0, n_in = 1'b0, z_in = 1'b0;
    logic         out_valid, n_out, z_out, c_out, wr_en, illegal;
    logic [W-1:0] result;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rmw_unit #(.DATA_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_nib(op_nib),
        .operand(operand), .c_in(c_in), .n_in(n_in), .z_in(z_in),
        .out_valid(out_valid), .result(result), .n_out(n_out),
        .z_out(z_out), .c_out(c_out), .wr_en(wr_en), .illegal(illegal)
    );

    // Expected state of the outputs, updated by the behavioural model.
    int e_v, e_r, e_n, e_z, e_c, e_w, e_i;

    function automatic string req_of(int nib);
        case (nib)
            0: return "R3";   3: return "R4";   4: return "R5";
            6, 9: return "R6";  7, 8: return "R7";
            10, 12: return "R8"; 13: return "R9"; 15: return "R10";
            default: return "R11";
        endcase
    endfunction

    // Behavioural reference: integer arithmetic per operation.
    task automatic model(int nib, int a, int ci, int ni, int zi);
        int r, c, n_forced;
        r = a; c = ci; n_forced = 0;
        e_w = 1; e_i = 0;
        case (nib)
            0:  begin r = (256 - a) % 256; c = (r != 0); end
            3:  begin r = 255 - a; c = 1; end
            4:  begin r = a / 2; c = a % 2; n_forced = 1; end
            6:  begin r = ci * 128 + a / 2; c = a % 2; end
            7:  begin r = (a >= 128 ? 128 : 0) + a / 2; c = a % 2; end
            8:  begin r = (a * 2) % 256; c = a / 128; end
            9:  begin r = (a * 2 + ci) % 256; c = a / 128; end
            10: r = (a + 255) % 256;
            12: r = (a + 1) % 256;
            13: begin r = a; e_w = 0; end
            15: begin r = 0; n_forced = 1; end
            default: begin e_i = 1; e_w = 0; end
        endcase
        e_r = r; e_c = c; e_v = 1;
        if (e_i == 1) begin e_n = ni; e_z = zi; end
        else begin
            e_n = n_forced ? 0 : r / 128;
            e_z = (r == 0);
        end
    endtask

    task automatic compare(string req);
        checks++;
        if (int'(out_valid) != e_v || int'(result) != e_r || int'(n_out) != e_n ||
            int'(z_out) != e_z || int'(c_out) != e_c || int'(wr_en) != e_w ||
            int'(illegal) != e_i) begin
            errors++;
            $display("FAIL %s: got v=%0d r=%02h n=%0d z=%0d c=%0d w=%0d i=%0d exp v=%0d r=%02h n=%0d z=%0d c=%0d w=%0d i=%0d",
                req, out_valid, result, n_out, z_out, c_out, wr_en, illegal,
                e_v, e_r, e_n, e_z, e_c, e_w, e_i);
        end
    endtask

    // Drive one accepted operation at a falling edge, check after the rise.
    task automatic apply(int nib, int a, int ci, int ni, int zi);
        @(negedge clk);
        in_valid = 1'b1; op_nib = nib[3:0]; operand = a[W-1:0];
        c_in = ci[0]; n_in = ni[0]; z_in = zi[0];
        model(nib, a, ci, ni, zi);
        @(posedge clk); #1;
        compare(req_of(nib));
        if (e_i == 0 && nib != 13 && wr_en !== 1'b1) begin
            errors++;
            $display("FAIL R12: wr_en=%0d exp 1 nib=%0h", wr_en, nib);
        end
    endtask

    // Idle cycle with scrambled inputs: outputs must hold, valid drops.
    task automatic idle(int seed);
        @(negedge clk);
        in_valid = 1'b0; op_nib = seed[3:0]; operand = seed[11:4];
        c_in = seed[0]; n_in = seed[1]; z_in = seed[2];
        e_v = 0;
        @(posedge clk); #1;
        compare("R2");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        e_v = 0; e_r = 0; e_n = 0; e_z = 0; e_c = 0; e_w = 0; e_i = 0;
        compare("R1");
        @(negedge clk); rst_n = 1'b1;
        // Directed corners
        apply(0, 8'h00, 1, 0, 0);   // R3 neg zero: C=0
        apply(0, 8'h80, 0, 0, 0);   // R3 neg 0x80
        apply(3, 8'hFF, 0, 1, 1);   // R4
        apply(4, 8'h01, 0, 1, 0);   // R5
        apply(6, 8'h01, 1, 0, 0);   // R6 ror
        apply(9, 8'h80, 1, 0, 0);   // R6 rol
        apply(7, 8'h81, 0, 0, 0);   // R7 asr
        apply(8, 8'h80, 0, 0, 0);   // R7 lsl
        apply(10, 8'h00, 1, 0, 0);  // R8 dec wrap
        apply(12, 8'hFF, 0, 0, 0);  // R8 inc wrap
        apply(13, 8'h00, 1, 1, 0);  // R9
        apply(15, 8'hA5, 1, 1, 0);  // R10
        apply(11, 8'h3C, 1, 1, 0);  // R11
        idle(12'h5A3);              // R2
        idle(12'hFFF);              // R2
        // Exhaustive sweep of nibble, operand and carry with interleaved idles
        for (int nib = 0; nib < 16; nib++) begin
            for (int a = 0; a < 256; a++) begin
                for (int ci = 0; ci < 2; ci++) begin
                    apply(nib, a, ci, (a + nib) % 2, (a / 2 + ci) % 2);
                end
                if (a % 64 == 7) idle(a * 17 + nib);
            end
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hang exp completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule